// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block picks the low-speed timebase for a real-time clock. It can take either a divided internal oscillator or an undivided external oscillator. Both sources arrive as single-cycle tick enables on the system clock. The internal path passes through a fixed divide-by-32 stage and then through a divider programmed by software. The result leaves as a tick enable, together with a second copy that software can gate off.

Software controls the block over a small 32-bit register bus. A write to the control word only lands when its upper half carries the unlock key 0x16AA. If the external oscillator disappears, the selection falls back to the internal path on its own, unless a bypass bit forbids this. A changed source or divider value is held back until the current internal period ends, so a consumer never sees a shortened period.

Top module: `losc_src_ctrl`

## Requirements
- R1: A write to offset 0x00 updates the control fields only when write data bits 31:16 equal 0x16AA. Any other upper half leaves the control fields unchanged. Control readback shows the source bit at bit 0, the external enable at bit 4 and the bypass at bit 15, with every other bit, key field included, reading zero.
- R2: The external source is in effect only when control bits 0 and 4 are both 1. `src_is_ext` then reads 1 and `sel_tick` equals `ext_tick` cycle for cycle, undivided.
- R3: On the internal source, `sel_tick` pulses once every 32*(N+1) cycles of `int_tick`. N is the 5-bit field at offset 0x08 bits 4:0, which reads back there with zeros above.
- R4: While bit 0 is set, bit 15 is clear and `ext_present` is 0, hardware clears bit 0 on the next clock. The block then returns to the internal source.
- R5: With bit 15 set, a low `ext_present` leaves bit 0 and the external source in place.
- R6: Offset 0x60 bit 0 gates the output. When it is 0, `gated_tick` stays 0. When it is 1, `gated_tick` equals `sel_tick`.
- R7: A new N value or a new source choice takes effect only at the next terminal count of the internal divider. The period already running completes at its old length.
- R8: After reset, all three registers read zero, the internal source is selected with N=0, and `src_is_ext` and `gated_tick` are 0.
- R9: Reads of any other offset return zero. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| int_tick | input | 1 | Internal oscillator tick enable |
| ext_tick | input | 1 | External oscillator tick enable |
| ext_present | input | 1 | External oscillator detected |
| sel_tick | output | 1 | Selected low-speed tick |
| gated_tick | output | 1 | Gated copy of `sel_tick` |
| src_is_ext | output | 1 | 1 while the external source is in effect |

## Verification
The assertions assume that `int_tick`, `ext_tick` and `ext_present` are synchronous to `clk`, and that a write strobe lasts one cycle per transfer. The bench drives every input half a cycle away from the active edge and holds `int_tick` high, which makes each internal period an exact cycle count. It drops `ext_present` only while it is watching the fallback and bypass behaviour. It restores the signal before the next test.

// File: rtl/losc_pkg.sv
package losc_pkg;
   localparam logic [15:0] UNLOCK_KEY = 16'h16AA;
   localparam int unsigned OFS_CTRL   = 'h00;
   localparam int unsigned OFS_PRESC  = 'h08;
   localparam int unsigned OFS_GATE   = 'h60;
   localparam int unsigned BIT_SEL    = 0;
   localparam int unsigned BIT_EXTEN  = 4;
   localparam int unsigned BIT_BYPASS = 15;
endpackage

// File: rtl/losc_regs.sv
module losc_regs
   import losc_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int PRESC_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               ext_present,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               sel_q,
   output logic               ext_en_q,
   output logic               byp_q,
   output logic [PRESC_W-1:0] presc_q,
   output logic               gate_q
);
   generate
      if (DATA_W < 32) begin : g_bad_dw
         $error("losc_regs: DATA_W must be at least 32");
      end
      if (PRESC_W < 1 || PRESC_W > 16) begin : g_bad_pw
         $error("losc_regs: PRESC_W out of range");
      end
   endgenerate

   logic hit_ctrl, hit_presc, hit_gate, key_ok, wr_ctrl, lost;

   assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_presc = (bus_addr == ADDR_W'(OFS_PRESC));
   assign hit_gate  = (bus_addr == ADDR_W'(OFS_GATE));
   assign key_ok    = (bus_wdata[31:16] == UNLOCK_KEY);
   assign wr_ctrl   = bus_we && hit_ctrl && key_ok;
   assign lost      = sel_q && !byp_q && !ext_present;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= 1'b0;
         ext_en_q <= 1'b0;
         byp_q    <= 1'b0;
      end else if (wr_ctrl) begin
         sel_q    <= bus_wdata[BIT_SEL];
         ext_en_q <= bus_wdata[BIT_EXTEN];
         byp_q    <= bus_wdata[BIT_BYPASS];
      end else if (lost) begin
         sel_q    <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
         gate_q  <= 1'b0;
      end else if (bus_we) begin
         if (hit_presc) presc_q <= bus_wdata[PRESC_W-1:0];
         if (hit_gate)  gate_q  <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[BIT_SEL]    = sel_q;
         bus_rdata[BIT_EXTEN]  = ext_en_q;
         bus_rdata[BIT_BYPASS] = byp_q;
      end else if (hit_presc) begin
         bus_rdata[PRESC_W-1:0] = presc_q;
      end else if (hit_gate) begin
         bus_rdata[0] = gate_q;
      end
   end

   // R1
   bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_ctrl && !key_ok && !lost) |=> ($stable(sel_q) && $stable(ext_en_q) && $stable(byp_q)));

   // R4
   fallback_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !byp_q && !ext_present && !wr_ctrl) |=> !sel_q);

   // R5
   bypass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && byp_q && !wr_ctrl) |=> sel_q);

   // R9
   unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !hit_ctrl && !hit_presc && !hit_gate) |=> ($stable(presc_q) && $stable(gate_q)));
endmodule

// File: rtl/losc_div.sv
module losc_div #(
   parameter int FIXED_DIV = 32,
   parameter int PRESC_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               int_tick,
   input  logic [PRESC_W-1:0] presc_q,
   output logic               div_tick
);
   localparam int FW = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;

   generate
      if (FIXED_DIV < 1) begin : g_bad_fd
         $error("losc_div: FIXED_DIV must be at least 1");
      end
   endgenerate

   logic               pre_pulse;
   logic [PRESC_W-1:0] pcnt, n_act;

   generate
      if (FIXED_DIV == 1) begin : g_nofix
         assign pre_pulse = int_tick;
      end else begin : g_fix
         logic [FW-1:0] fcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               fcnt <= '0;
            else if (int_tick)
               fcnt <= (fcnt == FW'(FIXED_DIV-1)) ? '0 : fcnt + 1'b1;
         end
         assign pre_pulse = int_tick && (fcnt == FW'(FIXED_DIV-1));
      end
   endgenerate

   assign div_tick = pre_pulse && (pcnt == n_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt  <= '0;
         n_act <= '0;
      end else if (pre_pulse) begin
         if (pcnt == n_act) begin
            pcnt  <= '0;
            n_act <= presc_q;
         end else begin
            pcnt  <= pcnt + 1'b1;
         end
      end
   end

   // R7
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_tick |=> $stable(n_act));

   // R3
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= n_act);
endmodule

// File: rtl/losc_src_mux.sv
module losc_src_mux (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_q,
   input  logic ext_en_q,
   input  logic gate_q,
   input  logic div_tick,
   input  logic ext_tick,
   output logic sel_tick,
   output logic gated_tick,
   output logic src_is_ext
);
   logic want_ext;

   assign want_ext = sel_q && ext_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         src_is_ext <= 1'b0;
      else if (div_tick)
         src_is_ext <= want_ext;
   end

   assign sel_tick   = src_is_ext ? ext_tick : div_tick;
   assign gated_tick = gate_q && sel_tick;

   // R7
   switch_on_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_tick |=> $stable(src_is_ext));

   // R2
   ext_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_tick && !(sel_q && ext_en_q)) |=> !src_is_ext);

   // R6
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gated_tick |-> (gate_q && sel_tick));
endmodule

// File: rtl/losc_src_ctrl.sv
module losc_src_ctrl #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int PRESC_W   = 5,
   parameter int FIXED_DIV = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              int_tick,
   input  logic              ext_tick,
   input  logic              ext_present,
   output logic              sel_tick,
   output logic              gated_tick,
   output logic              src_is_ext
);
   logic               sel_q, ext_en_q, byp_q, gate_q, div_tick;
   logic [PRESC_W-1:0] presc_q;

   losc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .ext_present(ext_present), .bus_rdata(bus_rdata),
      .sel_q(sel_q), .ext_en_q(ext_en_q), .byp_q(byp_q), .presc_q(presc_q),
      .gate_q(gate_q)
   );

   losc_div #(.FIXED_DIV(FIXED_DIV), .PRESC_W(PRESC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .presc_q(presc_q),
      .div_tick(div_tick)
   );

   losc_src_mux u_mux (
      .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .ext_en_q(ext_en_q),
      .gate_q(gate_q), .div_tick(div_tick), .ext_tick(ext_tick),
      .sel_tick(sel_tick), .gated_tick(gated_tick), .src_is_ext(src_is_ext)
   );

   // R8
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!src_is_ext && !gated_tick));
endmodule

// File: tb/losc_src_ctrl_bench.sv
module losc_src_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        int_tick = 1'b1;
   logic        ext_tick = 1'b0;
   logic        ext_present = 1'b1;
   logic        sel_tick, gated_tick, src_is_ext;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   losc_src_ctrl u_losc_src_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_tick(int_tick),
      .ext_tick(ext_tick), .ext_present(ext_present), .sel_tick(sel_tick),
      .gated_tick(gated_tick), .src_is_ext(src_is_ext)
   );

   task automatic expect_item(input string tag, input int v);
      tag_q.push_back(tag);
      exp_q.push_back(v);
   endtask

   task automatic observe(input int got);
      string tag;
      int    e;
      tag = tag_q.pop_front();
      e   = exp_q.pop_front();
      checks++;
      if (got != e) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, e);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output int v);
      @(negedge clk);
      bus_addr = a;
      #1 v = int'(bus_rdata);
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (!sel_tick);
   endtask

   task automatic gap(output int n);
      wait_pulse();
      n = 0;
      do begin @(negedge clk); n++; end while (!sel_tick);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_tests();
      int v, t0;
      // R8 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_item("R8 ctrl", 0);  rd(8'h00, v); observe(v);
      expect_item("R8 presc", 0); rd(8'h08, v); observe(v);
      expect_item("R8 gate", 0);  rd(8'h60, v); observe(v);
      expect_item("R8 src", 0);   observe(int'(src_is_ext));
      expect_item("R8 gated", 0); observe(int'(gated_tick));
      // R3 N=0 period
      expect_item("R3 N=0 period", 32); gap(v); observe(v);
      // R7 change waits for terminal count
      wait_pulse(); t0 = cyc;
      wr(8'h08, 32'hFFFF_FFE3);
      expect_item("R3 presc readback", 3); rd(8'h08, v); observe(v);
      wait_pulse();
      expect_item("R7 old period kept", 32); observe(cyc - t0);
      expect_item("R3 N=3 period", 128); gap(v); observe(v);
      wr(8'h08, 32'h1F);
      gap(v); gap(v);
      expect_item("R3 N=31 period", 1024); observe(v);
      wr(8'h08, 32'h0);
      gap(v); gap(v);
      // R1 bad key ignored
      wr(8'h00, 32'h16AB_8011);
      expect_item("R1 bad key", 0); rd(8'h00, v); observe(v);
      idle(40);
      expect_item("R1 bad key src", 0); observe(int'(src_is_ext));
      // R2 sel without enable stays internal
      wr(8'h00, 32'h16AA_0001);
      idle(40);
      expect_item("R2 no enable", 0); observe(int'(src_is_ext));
      // R1/R2 good key selects external
      wr(8'h00, 32'h16AA_0011);
      expect_item("R1 readback", 32'h11); rd(8'h00, v); observe(v);
      idle(40);
      expect_item("R2 src ext", 1); observe(int'(src_is_ext));
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); ext_tick = i[0];
         #1 expect_item("R2 follow ext", int'(i[0])); observe(int'(sel_tick));
      end
      // R6 gate
      @(negedge clk); ext_tick = 1'b1;
      #1 expect_item("R6 gate off", 0); observe(int'(gated_tick));
      wr(8'h60, 32'h1);
      ext_tick = 1'b1;
      #1 expect_item("R6 gate on", 1); observe(int'(gated_tick));
      @(negedge clk); ext_tick = 1'b0;
      #1 expect_item("R6 gate follows", 0); observe(int'(gated_tick));
      // R9 unmapped
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h16AA_0000);
      expect_item("R9 read 04", 0); rd(8'h04, v); observe(v);
      expect_item("R9 ctrl kept", 32'h11); rd(8'h00, v); observe(v);
      expect_item("R9 presc kept", 0); rd(8'h08, v); observe(v);
      expect_item("R9 gate kept", 1); rd(8'h60, v); observe(v);
      // R4 fallback
      @(negedge clk); ext_present = 1'b0;
      expect_item("R4 bit0 cleared", 32'h10); rd(8'h00, v); observe(v);
      idle(40);
      expect_item("R4 back to internal", 0); observe(int'(src_is_ext));
      @(negedge clk); ext_present = 1'b1;
      // R5 bypass
      wr(8'h00, 32'h16AA_8011);
      idle(40);
      @(negedge clk); ext_present = 1'b0;
      idle(40);
      expect_item("R5 bit0 kept", 32'h8011); rd(8'h00, v); observe(v);
      expect_item("R5 still ext", 1); observe(int'(src_is_ext));
      @(negedge clk); ext_present = 1'b1;
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (200000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule